// File: doc/BRIEF.md
# Virtual Channel Egress Arbiter

This block decides, every clock, which of up to eight virtual channels (VCs) may send on one shared egress port. A 3-bit extension count sets how many VCs exist beyond VC0. A 3-bit group count marks a low-priority group of VCs that starts at VC0. Every enabled VC outside the group takes part in strict priority, and the highest index wins. A VC inside the group is served only when no VC outside the group is requesting.

Inside the group, a 3-bit scheme select picks one of four schemes. Value 0 gives a hardwired round robin. Values 1, 2 and 3 give a weighted round robin that walks a phase table of 32, 64 or 128 entries. Each table entry names a VC. Software writes entries into a staging table, and every write raises a pending flag. A write of 1 to the load bit starts a copy of the staging table into the active table, one entry per clock. The pending flag drops when the copy has been applied. The grant is a combinational one-hot vector that answers the request vector in the same cycle.

Top module: `vc_egress_arb`

## Requirements
- R1: VC i is enabled only when i is at most cfg_ext_cnt. A request from a VC above that index is never granted.
- R2: When cfg_grp_cnt is 0, the grant goes to the highest-numbered enabled VC that is requesting.
- R3: An enabled VC with index at or above cfg_grp_cnt beats every group VC, and the highest such index wins. In such a cycle the round-robin pointer and the phase pointer keep their values.
- R4: gnt is zero or one-hot and a subset of req. It is valid in the same cycle as req. It is zero when no enabled VC is requesting.
- R5: With cfg_sched equal to 0 (values 4 to 7 behave the same way), the group uses round robin. The first grant after reset goes to the lowest requesting group VC. After that, the search starts one index above the VC granted last and wraps.
- R6: With cfg_sched equal to 1, 2 or 3, the group walks 32, 64 or 128 phases. In each cycle the group is served, the VC named by the current entry is granted if it requests; otherwise no grant is given. In either case the phase pointer advances by one and wraps to 0 after the last phase.
- R7: A table write (tbl_wr) makes tbl_pending read 1 after the next clock edge.
- R8: A write with ld_wr=1 and ld_wdata=1 copies one entry per clock. tbl_pending falls 128 edges after the load edge. The previous active table stays in use until then. A load issued while a copy is running is ignored.
- R9: A write with ld_wr=1 and ld_wdata=0 starts no copy and leaves tbl_pending unchanged. ld_rdata always reads 0.
- R10: After reset: gnt is 0, tbl_pending is 0, every active entry names VC0, and both the round-robin pointer and the phase pointer are 0.
- R11: A table write made while a copy is running leaves tbl_pending at 1 after that copy ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_cnt | input | 3 | Number of VCs beyond VC0 |
| cfg_grp_cnt | input | 3 | Size of the low-priority group, starting at VC0 |
| cfg_sched | input | 3 | Group scheme: 0 round robin, 1/2/3 phase table of 32/64/128 |
| tbl_wr | input | 1 | Staging table write strobe |
| tbl_wr_idx | input | 7 | Entry index to write |
| tbl_wr_vc | input | 3 | VC number stored in the entry |
| ld_wr | input | 1 | Write strobe for the load bit |
| ld_wdata | input | 1 | Value written to the load bit |
| ld_rdata | output | 1 | Read value of the load bit (always 0) |
| tbl_pending | output | 1 | Staged table not yet applied |
| req | input | 8 | Request vector, one bit per VC |
| gnt | output | 8 | One-hot grant vector |

## Verification
The grant depends only on the current req and on state, so it is due in the same cycle as the request. Table writes appear on tbl_pending one edge later, and a load clears it 128 edges after the load edge. The driver sets every input on a falling edge and queues the expected grant and, where it applies, the expected pending value for that cycle. The monitor compares them 2 ns after that same falling edge, when the combinational outputs have settled and the state reflects every rising edge before it. Copy timing is checked at the exact boundary cycles, 128 and 129 after the load step.

// File: rtl/vcarb_pkg.sv
package vcarb_pkg;

  typedef enum logic [2:0] {
    SCH_RR     = 3'd0,
    SCH_WRR32  = 3'd1,
    SCH_WRR64  = 3'd2,
    SCH_WRR128 = 3'd3
  } sched_e;

  function automatic int sched_phases(input sched_e s);
    case (s)
      SCH_WRR32:  return 32;
      SCH_WRR64:  return 64;
      SCH_WRR128: return 128;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/vcarb_masks.sv
module vcarb_masks #(
  parameter  int NUM_VC = 8,
  localparam int VC_W   = $clog2(NUM_VC)
) (
  input  logic [VC_W-1:0]   ext_cnt,
  input  logic [VC_W-1:0]   grp_cnt,
  output logic [NUM_VC-1:0] en_mask,
  output logic [NUM_VC-1:0] grp_mask
);

  for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
    assign en_mask[g]  = (32'(g) <= 32'(ext_cnt));
    assign grp_mask[g] = en_mask[g] && (32'(g) < 32'(grp_cnt));
  end

endmodule

// File: rtl/vcarb_rr.sv
module vcarb_rr #(
  parameter  int NUM_VC = 8,
  localparam int VC_W   = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] req,
  input  logic              adv,
  output logic [NUM_VC-1:0] gnt
);

  logic [VC_W-1:0] ptr_q, ptr_d, pick;
  logic            pick_ok;

  always_comb begin
    int idx;
    pick    = ptr_q;
    pick_ok = 1'b0;
    for (int k = NUM_VC - 1; k >= 0; k--) begin
      idx = (int'(ptr_q) + k) % NUM_VC;
      if (req[idx]) begin
        pick    = VC_W'(idx);
        pick_ok = 1'b1;
      end
    end
    gnt   = pick_ok ? (NUM_VC'(1) << pick) : '0;
    ptr_d = (adv && pick_ok) ? VC_W'((int'(pick) + 1) % NUM_VC) : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  // R5: the round-robin pick is a requesting VC
  a_r5_pick_requesting: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/vcarb_tables.sv
module vcarb_tables #(
  parameter  int NUM_VC = 8,
  parameter  int MAX_PH = 128,
  localparam int VC_W   = $clog2(NUM_VC),
  localparam int PH_W   = $clog2(MAX_PH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PH_W-1:0] wr_idx,
  input  logic [VC_W-1:0] wr_vc,
  input  logic            load_go,
  input  logic [PH_W-1:0] rd_idx,
  output logic [VC_W-1:0] rd_vc,
  output logic            pending
);

  logic [VC_W-1:0] stage_q [MAX_PH];
  logic [VC_W-1:0] bank_q  [2][MAX_PH];
  logic            act_q, act_d;
  logic            copy_q, copy_d;
  logic [PH_W-1:0] cidx_q, cidx_d;
  logic            pend_q, pend_d;
  logic            dirty_q, dirty_d;
  logic            start, last;

  always_comb begin
    start   = load_go && !copy_q;
    last    = copy_q && (cidx_q == PH_W'(MAX_PH - 1));
    copy_d  = start ? 1'b1 : (last ? 1'b0 : copy_q);
    cidx_d  = start ? '0 : (copy_q ? cidx_q + 1'b1 : cidx_q);
    act_d   = last ? ~act_q : act_q;
    dirty_d = start ? 1'b0 : ((wr_en && copy_q) ? 1'b1 : dirty_q);
    pend_d  = wr_en ? 1'b1 : ((last && !dirty_q) ? 1'b0 : pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      copy_q  <= 1'b0;
      cidx_q  <= '0;
      pend_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      copy_q  <= copy_d;
      cidx_q  <= cidx_d;
      pend_q  <= pend_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_PH; i++) begin
        stage_q[i]   <= '0;
        bank_q[0][i] <= '0;
        bank_q[1][i] <= '0;
      end
    end else begin
      if (wr_en) stage_q[wr_idx] <= wr_vc;
      if (copy_q) bank_q[~act_q][cidx_q] <= stage_q[cidx_q];
    end
  end

  assign rd_vc   = bank_q[act_q][rd_idx];
  assign pending = pend_q;

  a_r7_write_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pending);
  a_r8_clear_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(copy_q));
  a_r8_old_table_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_q && !last) |=> $stable(act_q));
  a_r9_zero_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_q && !load_go) |=> !copy_q);

endmodule

// File: rtl/vc_egress_arb.sv
module vc_egress_arb
  import vcarb_pkg::*;
#(
  parameter  int NUM_VC = 8,
  parameter  int MAX_PH = 128,
  localparam int VC_W   = $clog2(NUM_VC),
  localparam int PH_W   = $clog2(MAX_PH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VC_W-1:0]   cfg_ext_cnt,
  input  logic [VC_W-1:0]   cfg_grp_cnt,
  input  logic [2:0]        cfg_sched,
  input  logic              tbl_wr,
  input  logic [PH_W-1:0]   tbl_wr_idx,
  input  logic [VC_W-1:0]   tbl_wr_vc,
  input  logic              ld_wr,
  input  logic              ld_wdata,
  output logic              ld_rdata,
  output logic              tbl_pending,
  input  logic [NUM_VC-1:0] req,
  output logic [NUM_VC-1:0] gnt
);

  logic [NUM_VC-1:0] en_mask, grp_mask, grp_req, hi_req, hi_gnt, rr_gnt;
  logic [VC_W-1:0]   ent_vc;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              wrr_on, grp_turn, rr_adv, ph_adv;
  int                ph_lim;

  vcarb_masks #(.NUM_VC(NUM_VC)) u_masks (
    .ext_cnt (cfg_ext_cnt),
    .grp_cnt (cfg_grp_cnt),
    .en_mask (en_mask),
    .grp_mask(grp_mask)
  );

  vcarb_rr #(.NUM_VC(NUM_VC)) u_rr (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (grp_req),
    .adv  (rr_adv),
    .gnt  (rr_gnt)
  );

  vcarb_tables #(.NUM_VC(NUM_VC), .MAX_PH(MAX_PH)) u_tables (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_wr),
    .wr_idx (tbl_wr_idx),
    .wr_vc  (tbl_wr_vc),
    .load_go(ld_wr && ld_wdata),
    .rd_idx (ph_q),
    .rd_vc  (ent_vc),
    .pending(tbl_pending)
  );

  always_comb begin
    grp_req = req & grp_mask;
    hi_req  = req & en_mask & ~grp_mask;
    hi_gnt  = '0;
    for (int i = 0; i < NUM_VC; i++) begin
      if (hi_req[i]) hi_gnt = NUM_VC'(1) << i;
    end
    ph_lim   = (sched_phases(sched_e'(cfg_sched)) < MAX_PH) ?
               sched_phases(sched_e'(cfg_sched)) : MAX_PH;
    wrr_on   = (ph_lim != 0);
    grp_turn = (hi_req == '0) && (grp_req != '0);
    rr_adv   = grp_turn && !wrr_on;
    ph_adv   = grp_turn && wrr_on;
    if (hi_req != '0)    gnt = hi_gnt;
    else if (!grp_turn)  gnt = '0;
    else if (wrr_on)     gnt = grp_req[ent_vc] ? (NUM_VC'(1) << ent_vc) : '0;
    else                 gnt = rr_gnt;
    ph_d = ((int'(ph_q) + 1) >= ph_lim) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else if (ph_adv) ph_q <= ph_d;
  end

  assign ld_rdata = 1'b0;

  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r4_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  a_r1_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~en_mask) == '0);
  a_r3_high_tier_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_req != '0) |-> ((gnt & grp_mask) == '0) && (gnt != '0));
  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_req != '0) |=> $stable(ph_q));

endmodule

// File: tb/vc_egress_arb_tb.sv
module vc_egress_arb_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cfg_ext_cnt, cfg_grp_cnt, cfg_sched;
  logic       tbl_wr, ld_wr, ld_wdata;
  logic [6:0] tbl_wr_idx;
  logic [2:0] tbl_wr_vc;
  logic [7:0] req;
  logic       ld_rdata, tbl_pending;
  logic [7:0] gnt;

  int checks   = 0;
  int failures = 0;

  typedef struct {
    logic [7:0] eg;
    int         ep;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  vc_egress_arb u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ext_cnt(cfg_ext_cnt), .cfg_grp_cnt(cfg_grp_cnt),
    .cfg_sched(cfg_sched), .tbl_wr(tbl_wr), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_vc(tbl_wr_vc),
    .ld_wr(ld_wr), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .tbl_pending(tbl_pending),
    .req(req), .gnt(gnt)
  );

  // Driver: one cycle of stimulus plus the expected result for that cycle
  task automatic step(input logic [7:0] r, input logic w, input int widx, input int wvc,
                      input logic lw, input logic ld, input logic [7:0] eg, input int ep,
                      input string tag);
    @(negedge clk);
    req = r; tbl_wr = w; tbl_wr_idx = 7'(widx); tbl_wr_vc = 3'(wvc);
    ld_wr = lw; ld_wdata = ld;
    sb.push_back('{eg, ep, tag});
  endtask

  task automatic cyc(input logic [7:0] r, input logic [7:0] eg, input int ep, input string tag);
    step(r, 1'b0, 0, 0, 1'b0, 1'b0, eg, ep, tag);
  endtask

  task automatic set_cfg(input int e, input int g, input int s);
    @(negedge clk);
    #3;
    req = '0; tbl_wr = 1'b0; ld_wr = 1'b0;
    cfg_ext_cnt = 3'(e); cfg_grp_cnt = 3'(g); cfg_sched = 3'(s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #3;
    rst_n = 1'b0; req = '0; tbl_wr = 1'b0; ld_wr = 1'b0; ld_wdata = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compare each queued expectation 2 ns after its falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (gnt !== e.eg) begin
          failures++;
          $display("FAIL %s gnt actual=%h expected=%h", e.tag, gnt, e.eg);
        end
        if (e.ep >= 0) begin
          checks++;
          if (tbl_pending !== e.ep[0]) begin
            failures++;
            $display("FAIL %s tbl_pending actual=%0b expected=%0b", e.tag, tbl_pending, e.ep[0]);
          end
        end
        checks++;
        if (ld_rdata !== 1'b0) begin
          failures++;
          $display("FAIL R9 ld_rdata actual=%0b expected=0", ld_rdata);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b1; req = '0; tbl_wr = 1'b0; ld_wr = 1'b0; ld_wdata = 1'b0;
    tbl_wr_idx = '0; tbl_wr_vc = '0;
    cfg_ext_cnt = 3'd7; cfg_grp_cnt = 3'd0; cfg_sched = 3'd0;
    do_reset();

    // R10 reset state, R2 fixed priority, R4 idle
    cyc(8'h00, 8'h00, 0, "R10");
    cyc(8'h53, 8'h40, -1, "R2");
    cyc(8'h01, 8'h01, -1, "R2");
    cyc(8'h00, 8'h00, -1, "R4");
    // R1 only VC0..VC3 enabled
    set_cfg(3, 0, 0);
    cyc(8'hF0, 8'h00, -1, "R1");
    cyc(8'hF2, 8'h02, -1, "R1");
    cyc(8'h0C, 8'h08, -1, "R1");
    // R3 strict tier above group, R5 round robin in group VC0..VC3
    set_cfg(7, 4, 0);
    cyc(8'h3F, 8'h20, -1, "R3");
    cyc(8'h0F, 8'h01, -1, "R5");
    cyc(8'h0F, 8'h02, -1, "R5");
    cyc(8'h0F, 8'h04, -1, "R5");
    cyc(8'h0F, 8'h08, -1, "R5");
    cyc(8'h0F, 8'h01, -1, "R5");
    cyc(8'h0A, 8'h02, -1, "R5");
    cyc(8'h0A, 8'h08, -1, "R5");
    cyc(8'h0A, 8'h02, -1, "R5");

    // Phase table, 32 phases
    do_reset();
    set_cfg(7, 4, 1);
    cyc(8'h00, 8'h00, 0, "R10");
    step(8'h00, 1'b1, 0, 2, 1'b0, 1'b0, 8'h00, 0, "R10");
    step(8'h00, 1'b1, 1, 1, 1'b0, 1'b0, 8'h00, 1, "R7");
    step(8'h00, 1'b1, 2, 3, 1'b0, 1'b0, 8'h00, 1, "R7");
    step(8'h00, 1'b1, 3, 0, 1'b0, 1'b0, 8'h00, 1, "R7");
    step(8'h00, 1'b0, 0, 0, 1'b1, 1'b0, 8'h00, 1, "R9");
    for (int i = 0; i < 3; i++) cyc(8'h00, 8'h00, 1, "R9");
    step(8'h00, 1'b0, 0, 0, 1'b1, 1'b1, 8'h00, 1, "R8");
    cyc(8'h04, 8'h00, -1, "R8");           // old table: entry 0 names VC0
    for (int i = 2; i <= 127; i++) cyc(8'h00, 8'h00, -1, "R8");
    cyc(8'h00, 8'h00, 1, "R8");            // 128th cycle after load step
    cyc(8'h00, 8'h00, 0, "R8");            // cleared after edge 128
    cyc(8'h12, 8'h10, -1, "R3");           // pointer stays at phase 1
    cyc(8'h0F, 8'h02, -1, "R6");
    cyc(8'h0F, 8'h08, -1, "R6");
    cyc(8'h0F, 8'h01, -1, "R6");
    for (int p = 4; p <= 31; p++) cyc(8'h01, 8'h01, -1, "R6");
    cyc(8'h04, 8'h04, -1, "R6");           // wrapped to phase 0
    cyc(8'h04, 8'h00, -1, "R6");           // phase 1 names VC1: no grant
    cyc(8'h08, 8'h08, -1, "R6");

    // R11 write during a running copy
    step(8'h00, 1'b0, 0, 0, 1'b1, 1'b1, 8'h00, 0, "R11");
    step(8'h00, 1'b1, 5, 1, 1'b0, 1'b0, 8'h00, -1, "R11");
    for (int i = 2; i <= 128; i++) cyc(8'h00, 8'h00, -1, "R11");
    cyc(8'h00, 8'h00, 1, "R11");
    cyc(8'h00, 8'h00, 1, "R11");

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule